// File: doc/BRIEF.md
# ALU Status Flag Generator

This block computes and holds the status word of a processor datapath. After an 8-bit or 16-bit add, subtract, increment or decrement, the ALU presents the two operands, the raw result and the carry out. When the update enable is high, the block captures six condition flags from those values: carry, auxiliary carry, parity, zero, sign and signed overflow. Three control flags are kept beside them: single-step trap, maskable-interrupt enable and string direction. Only an explicit command sets or clears a control flag. Arithmetic never touches them.

The flag word is registered and appears one clock after the update or command. With the direction flag clear, string addresses count up. With it set, they count down. In 8-bit mode the upper byte of the result is ignored. Parity always looks at the low eight result bits, whatever the width.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the flag word becomes all zeros at that edge.
- R2: For ADD (op 0) and SUB (op 1), the carry flag (bit 0) takes `cout_i`. For INC (op 2) and DEC (op 3), the carry flag keeps its previous value.
- R3: The auxiliary carry flag (bit 4) is set when a carry or borrow passes from result bit 3 into bit 4.
- R4: The parity flag (bit 2) is set when result bits 7..0 hold an even number of ones, in both widths.
- R5: The zero flag (bit 6) is set when the result is zero within the selected width. In 8-bit mode (`wide_i` = 0), result bits 15..8 are ignored.
- R6: The sign flag (bit 7) copies result bit 15 when `wide_i` = 1 and result bit 7 when `wide_i` = 0.
- R7: The overflow flag (bit 11) is set as follows, using the sign bit of the selected width:
  - for ADD and INC, when both operands have the same sign and the result sign differs from it;
  - for SUB and DEC, when the operand signs differ and the result sign differs from operand A.
- R8: With `ctl_en_i` high, `ctl_sel_i` picks a control flag and `ctl_set_i` is written into it. Select 0 is trap (bit 8), 1 is interrupt enable (bit 9), 2 is direction (bit 10) and 3 changes nothing. Arithmetic updates never change these three bits.
- R9: While both `upd_en_i` and `ctl_en_i` are low, the flag word holds, whatever the other inputs do.
- R10: Bits 1, 3, 5, 12, 13, 14 and 15 of the flag word always read zero.
- R11: An update or command shows on `flags_o` one clock edge after it is presented. It is not visible before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| upd_en_i | input | 1 | Capture the condition flags this cycle |
| op_i | input | 2 | Operation: 0 ADD, 1 SUB, 2 INC, 3 DEC |
| wide_i | input | 1 | 1 selects 16-bit, 0 selects 8-bit |
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B |
| res_i | input | 16 | Raw ALU result |
| cout_i | input | 1 | Carry or borrow out of the selected width |
| ctl_en_i | input | 1 | Control flag command strobe |
| ctl_sel_i | input | 2 | Control flag select: 0 trap, 1 interrupt, 2 direction, 3 none |
| ctl_set_i | input | 1 | Value written into the selected control flag |
| flags_o | output | 16 | Registered flag word |

## Verification
The assertions check on every cycle:
- clearing by reset;
- holding while idle;
- the always-zero bits;
- carry retention on increment and decrement;
- the low-byte parity and 16-bit sign capture;
- the rule that arithmetic leaves the control flags alone.

Only the bench's scenarios can show that the auxiliary carry, zero and overflow equations are correct across widths and operation types. The same holds for the ignored upper result byte in 8-bit mode, the no-op command select and the one-cycle latency. The bench does this by comparing against a model that derives each flag from its own operand arithmetic.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int FLAG_W = 16;
  localparam int CF_BIT = 0;
  localparam int PF_BIT = 2;
  localparam int AF_BIT = 4;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int TF_BIT = 8;
  localparam int IE_BIT = 9;
  localparam int DF_BIT = 10;
  localparam int OF_BIT = 11;
  localparam logic [FLAG_W-1:0] USED_MASK = 16'h0FD5;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_INC = 2'd2,
    OP_DEC = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SEL_TRAP = 2'd0,
    SEL_IE   = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } ctl_sel_e;
endpackage

// File: rtl/parity_even.sv
module parity_even #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  output logic         even_o
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  generate
    for (genvar k = 0; k < W; k++) begin : g_xor
      assign chain[k+1] = chain[k] ^ d_i[k];
    end
  endgenerate
  assign even_o = ~chain[W];
endmodule

// File: rtl/cond_flags.sv
module cond_flags
  import flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAR_W  = 8
) (
  input  logic              wide_i,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cout_i,
  output logic              cf_o,
  output logic              cf_upd_o,
  output logic              af_o,
  output logic              pf_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NIB    = 4;

  logic sa, sb, sr, is_sub;
  logic unused_opnd;

  assign unused_opnd = ^{a_i, b_i};

  always_comb begin
    sa     = wide_i ? a_i[DATA_W-1]   : a_i[HALF_W-1];
    sb     = wide_i ? b_i[DATA_W-1]   : b_i[HALF_W-1];
    sr     = wide_i ? res_i[DATA_W-1] : res_i[HALF_W-1];
    is_sub = (op_i == OP_SUB) || (op_i == OP_DEC);
  end

  always_comb begin
    cf_o     = cout_i;
    cf_upd_o = (op_i == OP_ADD) || (op_i == OP_SUB);
    af_o     = a_i[NIB] ^ b_i[NIB] ^ res_i[NIB];
    zf_o     = wide_i ? (res_i == '0) : (res_i[HALF_W-1:0] == '0);
    sf_o     = sr;
    of_o     = is_sub ? ((sa != sb) && (sr != sa))
                      : ((sa == sb) && (sr != sa));
  end

  parity_even #(.W(PAR_W)) u_par (
    .d_i    (res_i[PAR_W-1:0]),
    .even_o (pf_o)
  );
endmodule

// File: rtl/ctl_flags.sv
module ctl_flags
  import flag_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       cmd_en_i,
  input  ctl_sel_e   sel_i,
  input  logic       set_i,
  output logic       tf_o,
  output logic       ie_o,
  output logic       df_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tf_o <= 1'b0;
      ie_o <= 1'b0;
      df_o <= 1'b0;
    end else if (cmd_en_i) begin
      case (sel_i)
        SEL_TRAP: tf_o <= set_i;
        SEL_IE:   ie_o <= set_i;
        SEL_DIR:  df_o <= set_i;
        default:  ;
      endcase
    end
  end

  AST_CTL_ONLY_BY_CMD: assert property (@(posedge clk_i) disable iff (rst_i)
    !cmd_en_i |=> $stable({tf_o, ie_o, df_o})); // R8
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              upd_en_i,
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cout_i,
  input  logic              ctl_en_i,
  input  logic [1:0]        ctl_sel_i,
  input  logic              ctl_set_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic cf_n, cf_upd, af_n, pf_n, zf_n, sf_n, of_n;
  logic cf_q, af_q, pf_q, zf_q, sf_q, of_q;
  logic tf, ie, df;

  cond_flags #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_cond (
    .wide_i   (wide_i),
    .op_i     (op_e'(op_i)),
    .a_i      (opa_i),
    .b_i      (opb_i),
    .res_i    (res_i),
    .cout_i   (cout_i),
    .cf_o     (cf_n),
    .cf_upd_o (cf_upd),
    .af_o     (af_n),
    .pf_o     (pf_n),
    .zf_o     (zf_n),
    .sf_o     (sf_n),
    .of_o     (of_n)
  );

  ctl_flags u_ctl (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cmd_en_i (ctl_en_i),
    .sel_i    (ctl_sel_e'(ctl_sel_i)),
    .set_i    (ctl_set_i),
    .tf_o     (tf),
    .ie_o     (ie),
    .df_o     (df)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cf_q <= 1'b0;
      af_q <= 1'b0;
      pf_q <= 1'b0;
      zf_q <= 1'b0;
      sf_q <= 1'b0;
      of_q <= 1'b0;
    end else if (upd_en_i) begin
      if (cf_upd) cf_q <= cf_n;
      af_q <= af_n;
      pf_q <= pf_n;
      zf_q <= zf_n;
      sf_q <= sf_n;
      of_q <= of_n;
    end
  end

  always_comb begin
    flags_o         = '0;
    flags_o[CF_BIT] = cf_q;
    flags_o[PF_BIT] = pf_q;
    flags_o[AF_BIT] = af_q;
    flags_o[ZF_BIT] = zf_q;
    flags_o[SF_BIT] = sf_q;
    flags_o[TF_BIT] = tf;
    flags_o[IE_BIT] = ie;
    flags_o[DF_BIT] = df;
    flags_o[OF_BIT] = of_q;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    rst_i |=> (flags_o == '0)); // R1
  AST_CF_KEPT: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_en_i && op_i[1]) |=> $stable(flags_o[CF_BIT])); // R2
  AST_PARITY_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    upd_en_i |=> (flags_o[PF_BIT] == ~^$past(res_i[PAR_W-1:0]))); // R4
  AST_SIGN_WIDE: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_en_i && wide_i) |=> (flags_o[SF_BIT] == $past(res_i[DATA_W-1]))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!upd_en_i && !ctl_en_i) |=> $stable(flags_o)); // R9
  AST_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (flags_o & ~USED_MASK) == '0); // R10
endmodule

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_en = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        wide = 1'b0;
  logic [15:0] opa = '0, opb = '0, res = '0;
  logic        cout = 1'b0;
  logic        ctl_en = 1'b0;
  logic [1:0]  ctl_sel = 2'd0;
  logic        ctl_set = 1'b0;
  logic [15:0] flags;

  int total = 0;
  int fails = 0;
  bit done  = 0;
  logic [15:0] exp_q = '0;

  always #4 clk = ~clk;

  alu_flag_unit u_alu_flag_unit (
    .clk_i(clk), .rst_i(rst), .upd_en_i(upd_en), .op_i(op), .wide_i(wide),
    .opa_i(opa), .opb_i(opb), .res_i(res), .cout_i(cout),
    .ctl_en_i(ctl_en), .ctl_sel_i(ctl_sel), .ctl_set_i(ctl_set),
    .flags_o(flags)
  );

  // {op, wide, A, B}
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 1'b1, 16'h7FFF, 16'h0001},
    {2'd0, 1'b1, 16'hFFFF, 16'h0001},
    {2'd1, 1'b1, 16'h8000, 16'h0001},
    {2'd1, 1'b1, 16'h0000, 16'h0001},
    {2'd0, 1'b0, 16'h12FF, 16'h3401},
    {2'd1, 1'b0, 16'h9980, 16'h6601},
    {2'd2, 1'b1, 16'hFFFF, 16'h0001},
    {2'd3, 1'b0, 16'h4400, 16'h0001},
    {2'd0, 1'b1, 16'h1234, 16'h1111},
    {2'd1, 1'b1, 16'h5555, 16'h5555},
    {2'd0, 1'b0, 16'h0040, 16'h0040},
    {2'd2, 1'b0, 16'h007F, 16'h0001}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic calc(input logic [1:0] o, input logic w, input logic [15:0] a, input logic [15:0] b,
                      output logic [15:0] r, output logic c);
    logic [16:0] am, bm, s;
    am = w ? {1'b0, a} : {9'b0, a[7:0]};
    bm = w ? {1'b0, b} : {9'b0, b[7:0]};
    if (o[0] == 1'b0) begin
      s = am + bm;
      c = w ? s[16] : s[8];
    end else begin
      s = am - bm;
      c = (am < bm);
    end
    r = w ? s[15:0] : {8'hA5, s[7:0]};
  endtask

  function automatic logic [15:0] model(input logic [1:0] o, input logic w, input logic [15:0] a,
                                        input logic [15:0] b, input logic [15:0] r, input logic c,
                                        input logic [15:0] prev);
    logic [15:0] f;
    logic sa, sb, sr, sub;
    sub = o[0];
    sa = w ? a[15] : a[7];
    sb = w ? b[15] : b[7];
    sr = w ? r[15] : r[7];
    f = prev & 16'h0701;                                   // R8 control bits and held carry
    if (!o[1]) f[0] = c;                                   // R2
    f[4]  = sub ? (a[3:0] < b[3:0]) : ({1'b0, a[3:0]} + {1'b0, b[3:0]} > 5'd15); // R3
    f[2]  = ($countones(r[7:0]) % 2) == 0;                 // R4
    f[6]  = w ? (r == 16'h0) : (r[7:0] == 8'h0);           // R5
    f[7]  = sr;                                            // R6
    f[11] = sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa); // R7
    return f;
  endfunction

  task automatic run_vec(input logic [1:0] o, input logic w, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r, e;
    logic c;
    calc(o, w, a, b, r, c);
    e = model(o, w, a, b, r, c, exp_q);
    @(negedge clk);
    op = o; wide = w; opa = a; opb = b; res = r; cout = c; upd_en = 1'b1;
    #1;
    check("R11 no early change", flags, exp_q);
    @(negedge clk);
    upd_en = 1'b0;
    check("R2 carry",       {15'b0, flags[0]},  {15'b0, e[0]});
    check("R3 aux carry",   {15'b0, flags[4]},  {15'b0, e[4]});
    check("R4 parity",      {15'b0, flags[2]},  {15'b0, e[2]});
    check("R5 zero",        {15'b0, flags[6]},  {15'b0, e[6]});
    check("R6 sign",        {15'b0, flags[7]},  {15'b0, e[7]});
    check("R7 overflow",    {15'b0, flags[11]}, {15'b0, e[11]});
    check("R10 word layout", flags, e);
    exp_q = e;
  endtask

  task automatic ctl_cmd(input logic [1:0] s, input logic v);
    @(negedge clk);
    ctl_en = 1'b1; ctl_sel = s; ctl_set = v;
    @(negedge clk);
    ctl_en = 1'b0;
    case (s)
      2'd0: exp_q[8]  = v;
      2'd1: exp_q[9]  = v;
      2'd2: exp_q[10] = v;
      default: ;
    endcase
    check("R8 control command", flags, exp_q);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", flags, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i][34:33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
    end

    // R2: carry set by ADD, then INC/DEC leave it
    run_vec(2'd0, 1'b1, 16'hFFFF, 16'h0002);
    run_vec(2'd3, 1'b1, 16'h0001, 16'h0001);
    check("R2 carry held over DEC", {15'b0, flags[0]}, 16'h0001);

    // R5: narrow zero with nonzero upper result byte (calc puts A5 there)
    run_vec(2'd1, 1'b0, 16'h3377, 16'h8877);
    check("R5 upper byte ignored", {15'b0, flags[6]}, 16'h0001);

    // R8 commands, including the no-op select
    ctl_cmd(2'd0, 1'b1);
    ctl_cmd(2'd1, 1'b1);
    ctl_cmd(2'd2, 1'b1);
    ctl_cmd(2'd3, 1'b0);
    ctl_cmd(2'd0, 1'b0);
    run_vec(2'd1, 1'b1, 16'h0000, 16'h0000);
    check("R8 arithmetic keeps controls", flags & 16'h0700, 16'h0600);

    // R9: inputs change without enables
    @(negedge clk);
    op = 2'd1; wide = 1'b1; opa = 16'h8000; opb = 16'h7FFF; res = 16'h0001; cout = 1'b1;
    ctl_sel = 2'd2; ctl_set = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 hold when idle", flags, exp_q);

    // R1 mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears", flags, 16'h0000);
    rst = 1'b0;

    done = 1;
    summary();
    $finish;
  end
endmodule